// File: doc/BRIEF.md
# Memory-Mapped GCD Accelerator

A small bus-attached peripheral that computes the greatest common divisor of two unsigned operands with an iterative subtract-and-compare engine. Software talks to it through a plain word-addressed register port (address, write enable, write data, read enable, read data). The operand and result registers are more than storage. Writing the second operand is a handshake that launches the engine. Reading the result is a handshake that hands the result back and frees the engine.

The usage sequence has four steps. Software polls status until the engine reports that it is ready. It then stores the first operand (X) and writes the second operand (Y), which is the trigger. Finally it polls status until a result is pending and reads the result. The engine keeps its own copy of both operands, so the X register may be rewritten while a computation runs.

Register map: status at byte offset 0x0 (read-only), X at 0x4 (write-only), Y at 0x8 (write-only), result at 0xC (read-only). Read data appears on `rdata_o` in the cycle after the read is sampled.

Top module: `gcd_mmio_periph`

## Requirements
- R1: After reset, a status read returns 1 (ready, no result pending) and a result read returns 0.
- R2: A write to X (offset 0x4) only stores the operand: status stays 1 and no computation starts.
- R3: A write to Y (offset 0x8) while the engine is ready launches a computation on the stored X and the written Y. For nonzero operands that are not both at their maximum, the next status read returns 0 (busy).
- R4: The result read at offset 0xC equals gcd(X, Y). If one operand is zero, the result is the other operand. If both are zero, the result is 0.
- R5: Status is a 2-bit field at offset 0x0, zero-extended to the data width. Bit 0 means the engine accepts new operands and bit 1 means a result is pending. A read returns the live value at the clock edge where the read is sampled, and the data appears on `rdata_o` the cycle after.
- R6: A pending result stays valid with a stable value until it is read. The read consumes it, and the next status read returns 1.
- R7: A write to Y while the engine is busy or a result is pending is ignored. The result comes from the operands that were accepted first.
- R8: A result read while no result is pending returns the last result and changes nothing.
- R9: Reads of any offset other than 0x0 and 0xC return 0. Writes to any offset other than 0x4 and 0x8 change no state.
- R10: When either operand is zero, the result is pending on the first cycle after the Y write. The next status read returns 2.
- R11: The data width is the parameter DATA_W, default 32. Two equal all-ones operands give an all-ones result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | ADDR_W | Byte address of the register access |
| we_i | input | 1 | Write enable |
| wdata_i | input | DATA_W | Write data |
| re_i | input | 1 | Read enable |
| rdata_o | output | DATA_W | Read data, registered one cycle after the read |

## Verification
The bench goes after the handshake side effects.

- A trigger write during a busy or pending state must not reload the engine. A design that accepts it returns the gcd of the second pair instead of the first.
- A result read with no result pending must not clear or alter anything. A design that gets this wrong loses the result or changes status.
- Zero operands and equal all-ones operands exercise the short paths through the engine. A wrong termination test there hangs the engine, returns zero, or returns a stale value.
- Writes to read-only or unmapped offsets must leave status and the stored X intact.

// File: rtl/gcd_mmio_pkg.sv
package gcd_mmio_pkg;
  typedef enum logic [1:0] {ENG_IDLE, ENG_BUSY, ENG_DONE} eng_state_e;

  localparam int unsigned OFF_STATUS = 0;
  localparam int unsigned OFF_X      = 4;
  localparam int unsigned OFF_Y      = 8;
  localparam int unsigned OFF_RES    = 12;

  typedef struct packed {
    logic wr_x;
    logic wr_y;
    logic rd_stat;
    logic rd_res;
  } acc_strobe_t;
endpackage

// File: rtl/gcd_reg_decode.sv
module gcd_reg_decode
  import gcd_mmio_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic              re_i,
  output acc_strobe_t       strb_o
);
  always_comb begin
    strb_o.wr_x    = we_i && (addr_i == ADDR_W'(OFF_X));
    strb_o.wr_y    = we_i && (addr_i == ADDR_W'(OFF_Y));
    strb_o.rd_stat = re_i && (addr_i == ADDR_W'(OFF_STATUS));
    strb_o.rd_res  = re_i && (addr_i == ADDR_W'(OFF_RES));
  end
endmodule

// File: rtl/gcd_engine.sv
module gcd_engine
  import gcd_mmio_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [DATA_W-1:0] x_i,
  input  logic [DATA_W-1:0] y_i,
  output logic              in_ready_o,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [DATA_W-1:0] res_o
);
  eng_state_e        state_q;
  logic [DATA_W-1:0] a_q, b_q, res_q;

  assign in_ready_o  = (state_q == ENG_IDLE);
  assign out_valid_o = (state_q == ENG_DONE);
  assign res_o       = res_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ENG_IDLE;
      a_q     <= '0;
      b_q     <= '0;
      res_q   <= '0;
    end else begin
      unique case (state_q)
        ENG_IDLE: if (in_valid_i) begin
          // zero operand: answer is the other one, no iteration
          if (x_i == '0 || y_i == '0) begin
            res_q   <= x_i | y_i;
            state_q <= ENG_DONE;
          end else begin
            a_q     <= x_i;
            b_q     <= y_i;
            state_q <= ENG_BUSY;
          end
        end
        ENG_BUSY: begin
          if (a_q == '0) begin
            res_q   <= b_q;
            state_q <= ENG_DONE;
          end else if (b_q == '0) begin
            res_q   <= a_q;
            state_q <= ENG_DONE;
          end else if (a_q >= b_q) begin
            a_q <= a_q - b_q;
          end else begin
            b_q <= b_q - a_q;
          end
        end
        ENG_DONE: if (out_ready_i) state_q <= ENG_IDLE;
        default: state_q <= ENG_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/gcd_glue.sv
module gcd_glue
  import gcd_mmio_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  acc_strobe_t       strb_i,
  input  logic              re_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              in_ready_i,
  input  logic              out_valid_i,
  input  logic [DATA_W-1:0] res_i,
  output logic [DATA_W-1:0] x_o,
  output logic              in_valid_o,
  output logic              out_ready_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned STAT_W = 2;

  logic [DATA_W-1:0] x_q, rdata_q, rd_mux;

  assign x_o         = x_q;
  assign in_valid_o  = strb_i.wr_y;
  assign out_ready_o = strb_i.rd_res;
  assign rdata_o     = rdata_q;

  always_comb begin
    rd_mux = '0;
    if (strb_i.rd_stat) rd_mux = {{(DATA_W-STAT_W){1'b0}}, out_valid_i, in_ready_i};
    else if (strb_i.rd_res) rd_mux = res_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_q     <= '0;
      rdata_q <= '0;
    end else begin
      if (strb_i.wr_x) x_q <= wdata_i;
      if (re_i) rdata_q <= rd_mux;
    end
  end
endmodule

// File: rtl/gcd_mmio_periph.sv
module gcd_mmio_periph
  import gcd_mmio_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              re_i,
  output logic [DATA_W-1:0] rdata_o
);
  acc_strobe_t       strb;
  logic              in_valid, in_ready, out_valid, out_ready;
  logic [DATA_W-1:0] x_val, res;

  gcd_reg_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i (addr_i),
    .we_i   (we_i),
    .re_i   (re_i),
    .strb_o (strb)
  );

  gcd_glue #(.DATA_W(DATA_W)) u_glue (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .strb_i      (strb),
    .re_i        (re_i),
    .wdata_i     (wdata_i),
    .in_ready_i  (in_ready),
    .out_valid_i (out_valid),
    .res_i       (res),
    .x_o         (x_val),
    .in_valid_o  (in_valid),
    .out_ready_o (out_ready),
    .rdata_o     (rdata_o)
  );

  gcd_engine #(.DATA_W(DATA_W)) u_eng (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (in_valid),
    .x_i         (x_val),
    .y_i         (wdata_i),
    .in_ready_o  (in_ready),
    .out_valid_o (out_valid),
    .out_ready_i (out_ready),
    .res_o       (res)
  );
endmodule

// File: rtl/gcd_mmio_chk.sv
module gcd_mmio_chk
  import gcd_mmio_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              we_i,
  input logic              re_i,
  input logic              in_ready_i,
  input logic              out_valid_i,
  input logic [DATA_W-1:0] res_i,
  input logic [DATA_W-1:0] rdata_i
);
  logic wr_y, rd_res, rd_unmapped;
  assign wr_y        = we_i && (addr_i == ADDR_W'(OFF_Y));
  assign rd_res      = re_i && (addr_i == ADDR_W'(OFF_RES));
  assign rd_unmapped = re_i && (addr_i != ADDR_W'(OFF_STATUS)) && (addr_i != ADDR_W'(OFF_RES));

  // R5
  status_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({in_ready_i, out_valid_i}));

  // R2
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_ready_i && !wr_y) |=> in_ready_i);

  // R3
  launch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_ready_i && wr_y) |=> !in_ready_i);

  // R6
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_i && !rd_res) |=> (out_valid_i && $stable(res_i)));

  // R6
  consume_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_i && rd_res) |=> (in_ready_i && !out_valid_i));

  // R8
  stale_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!out_valid_i && rd_res) |=> (rdata_i == $past(res_i)));

  // R9
  unmapped_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_unmapped |=> (rdata_i == '0));
endmodule

bind gcd_mmio_periph gcd_mmio_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .addr_i      (addr_i),
  .we_i        (we_i),
  .re_i        (re_i),
  .in_ready_i  (in_ready),
  .out_valid_i (out_valid),
  .res_i       (res),
  .rdata_i     (rdata_o)
);

// File: tb/gcd_mmio_periph_test.sv
module gcd_mmio_periph_test;
  localparam int unsigned DW = 32;
  localparam int unsigned AW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          we = 1'b0;
  logic          re = 1'b0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  gcd_mmio_periph #(.DATA_W(DW), .ADDR_W(AW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we),
    .wdata_i(wdata), .re_i(re), .rdata_o(rdata)
  );

  function automatic logic [DW-1:0] gcd_ref(input logic [DW-1:0] a, input logic [DW-1:0] b);
    logic [DW-1:0] t;
    while (b != 0) begin
      t = a % b;
      a = b;
      b = t;
    end
    return a;
  endfunction

  task automatic chk(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  // tasks are entered at a falling edge and leave at a falling edge
  task automatic bus_wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic bus_rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
    addr = a; re = 1'b1;
    @(negedge clk);
    d = rdata;
    re = 1'b0;
  endtask

  task automatic poll_done(input string tag);
    logic [DW-1:0] s;
    for (int i = 0; i < 3000; i++) begin
      bus_rd(4'h0, s);
      if (s[1]) return;
    end
    chk(tag, s, 32'h2);
  endtask

  task automatic run_pair(input string tag, input logic [DW-1:0] x, input logic [DW-1:0] y);
    logic [DW-1:0] r;
    bus_wr(4'h4, x);
    bus_wr(4'h8, y);
    poll_done(tag);
    bus_rd(4'hC, r);
    chk(tag, r, gcd_ref(x, y));
    bus_rd(4'h0, r);
    chk({tag, " R6 freed"}, r, 32'h1);
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
      end
    end
  end

  initial begin
    logic [DW-1:0] r;
    logic [DW-1:0] rx, ry;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    bus_rd(4'h0, r); chk("R1 status", r, 32'h1);
    bus_rd(4'hC, r); chk("R1 result", r, 32'h0);

    // R2 X write starts nothing
    bus_wr(4'h4, 32'd55);
    bus_rd(4'h0, r); chk("R2 status after X", r, 32'h1);

    // R9 unmapped / write-only reads give 0; stray writes change nothing
    bus_rd(4'h4, r); chk("R9 read X offset", r, 32'h0);
    bus_rd(4'h2, r); chk("R9 read 0x2", r, 32'h0);
    bus_wr(4'h0, 32'hFFFF_FFFF);
    bus_wr(4'hC, 32'd7);
    bus_wr(4'h6, 32'd9);
    bus_rd(4'h0, r); chk("R9 status after stray writes", r, 32'h1);
    bus_wr(4'h8, 32'd22);   // uses stored X = 55
    poll_done("R9 poll");
    bus_rd(4'hC, r); chk("R9 stored X intact", r, 32'd11);

    // R4 directed
    run_pair("R4 48,18", 32'd48, 32'd18);
    run_pair("R4 17,13", 32'd17, 32'd13);
    run_pair("R4 12,36", 32'd12, 32'd36);

    // R10 zero operands: pending right after trigger
    bus_wr(4'h4, 32'd0); bus_wr(4'h8, 32'd0);
    bus_rd(4'h0, r); chk("R10 both zero status", r, 32'h2);
    bus_rd(4'hC, r); chk("R4 both zero result", r, 32'h0);
    bus_wr(4'h4, 32'd0); bus_wr(4'h8, 32'd7);
    bus_rd(4'h0, r); chk("R10 x zero status", r, 32'h2);
    bus_rd(4'hC, r); chk("R4 x zero result", r, 32'd7);
    bus_wr(4'h4, 32'd9); bus_wr(4'h8, 32'd0);
    bus_rd(4'h0, r); chk("R10 y zero status", r, 32'h2);
    bus_rd(4'hC, r); chk("R4 y zero result", r, 32'd9);

    // R3 / R7 launch, then ignored trigger while busy
    bus_wr(4'h4, 32'd1000);
    bus_wr(4'h8, 32'd3);
    bus_rd(4'h0, r); chk("R3 busy status", r, 32'h0);
    bus_wr(4'h4, 32'd20);
    bus_wr(4'h8, 32'd10);
    bus_rd(4'h0, r); chk("R7 still busy", r, 32'h0);
    poll_done("R7 poll");
    bus_rd(4'hC, r); chk("R7 busy write ignored", r, 32'd1);

    // R8 stale read: same value, no side effect
    bus_rd(4'hC, r); chk("R8 stale result", r, 32'd1);
    bus_rd(4'h0, r); chk("R8 status unchanged", r, 32'h1);

    // R6 / R7 pending result held, trigger while pending ignored
    bus_wr(4'h4, 32'd48);
    bus_wr(4'h8, 32'd18);
    poll_done("R6 poll");
    repeat (5) @(negedge clk);
    bus_rd(4'h0, r); chk("R6 still pending", r, 32'h2);
    bus_wr(4'h8, 32'd5);
    bus_rd(4'h0, r); chk("R7 pending write ignored", r, 32'h2);
    bus_rd(4'hC, r); chk("R6 held result", r, 32'd6);
    bus_rd(4'h0, r); chk("R6 consumed", r, 32'h1);

    // R11 equal all-ones operands
    run_pair("R11 all ones", 32'hFFFF_FFFF, 32'hFFFF_FFFF);

    // R4 random pairs (10-bit to bound iteration count)
    for (int i = 0; i < 40; i++) begin
      rx = $urandom & 32'h3FF;
      ry = $urandom & 32'h3FF;
      run_pair("R4 random", rx, ry);
    end

    finish_run();
  end
endmodule